// File: doc/BRIEF.md
# Coprocessor Start Sequencer

This block decides how a network coprocessor comes out of reset and what each host attention strobe means. It receives an asynchronous active-high reset request, an asynchronous attention strobe from the host, a transmit clock from the serial side, and a host port through which 32-bit words are written. It synchronizes the asynchronous inputs into the system clock domain. It qualifies the reset request against a minimum number of system clock cycles and a minimum number of transmit clock edges. It then drives a level `coreReset` that aborts the rest of the coprocessor.

After a qualified reset, or after power-up, the block sits idle. The first falling edge of the attention strobe produces an initialization pulse together with the address where the startup structure is to be fetched. That address is a fixed default unless the host has committed one through the port beforehand. Every later attention falling edge produces a command pulse instead.

A port access is two strobes. The first strobe holds the data word. The second strobe commits the held word, and the data present on the second strobe is not used. The low nibble of the held word selects the access type.

Top module: `startSequencer`

## Requirements
- R1: `coreReset` rises only after `resetIn`, once synchronized, has stayed high for at least 5 system clock cycles and at least 4 rising `txClk` edges have been counted while it stays high. A request held for fewer than 5 cycles never raises `coreReset`, and a request held with `txClk` stopped never raises it either.
- R2: `coreReset` falls within a few cycles of `resetIn` going low. While `coreReset` is high, attention strobes and port writes have no effect.
- R3: After power-up or a qualified reset, the first attention falling edge gives exactly one `initStart` pulse. Unless an address was committed, `initAddr` is 32'h00FFFFF6 during that pulse.
- R4: Every attention falling edge after the first gives exactly one `cmdStart` pulse and no `initStart`.
- R5: A port access consists of two `portStrobe` cycles. The first holds `portData`; the second commits the held word. If the held bits [3:0] equal 4'b0010, the start address becomes {held[31:4], 4'b0000} and is used by the next initialization. Any other type code leaves the address unchanged.
- R6: A qualified reset discards any committed start address and any half-finished port access.
- R7: `initStart` and `cmdStart` last one system clock cycle each and are never high in the same cycle.
- R8: A commit whose second strobe is sampled in the same cycle as the attention falling edge is recognized applies to the initialization started by that edge.
- R9: The attention strobe acts on its falling edge only. Holding it high produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| sysRstN | input | 1 | Power-on reset of the block's own state, active low |
| txClk | input | 1 | Transmit clock, asynchronous to `clk` |
| resetIn | input | 1 | Host reset request, active high, asynchronous |
| attnIn | input | 1 | Host attention strobe, asynchronous |
| portStrobe | input | 1 | Host port write strobe, one `clk` cycle per write |
| portData | input | 32 | Host port data word |
| coreReset | output | 1 | Qualified reset level for the coprocessor |
| initStart | output | 1 | One-cycle pulse: begin initialization |
| initAddr | output | 32 | Start address, valid with `initStart` |
| cmdStart | output | 1 | One-cycle pulse: begin command execution |

## Verification
Two events can land in the same system clock cycle: the commit of a port address and the recognition of the attention falling edge that starts initialization. The bench releases the attention strobe and times the second port strobe so that it is sampled exactly two edges later, which is the edge at which the falling edge is acted on. It then expects `initAddr` during the resulting `initStart` pulse to be the newly committed address rather than the default. Every pulse is also counted, and the count of cycles with both pulses high must stay zero.

// File: rtl/startSeqPkg.sv
package startSeqPkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned TYPE_W = 4;
  localparam logic [WORD_W-1:0] DEFAULT_START = 32'h00FFFFF6;
  localparam logic [TYPE_W-1:0] PORT_SET_START = 4'b0010;

  typedef struct packed {
    logic clearAll;
    logic latchInit;
  } seqStrobe_t;
endpackage

// File: rtl/startRstQual.sv
module startRstQual #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SYS_MIN = 5,
  parameter int unsigned TX_MIN = 4
) (
  input  logic clk,
  input  logic sysRstN,
  input  logic txClk,
  input  logic resetIn,
  output logic coreReset
);
  localparam int unsigned SYS_W = $clog2(SYS_MIN + 1);
  localparam int unsigned TX_W = $clog2(TX_MIN + 1);
  localparam logic [SYS_W-1:0] SYS_LIM = SYS_W'(SYS_MIN);
  localparam logic [TX_W-1:0] TX_LIM = TX_W'(TX_MIN);

  logic [SYNC_STAGES-1:0] rstChain;
  logic [SYNC_STAGES:0] txChain;
  logic rstLvl;
  logic txEdge;
  logic [SYS_W-1:0] sysCnt;
  logic [TX_W-1:0] txCnt;
  logic sysDone;
  logic txDone;

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      rstChain <= '0;
      txChain <= '0;
    end else begin
      rstChain <= {rstChain[SYNC_STAGES-2:0], resetIn};
      txChain <= {txChain[SYNC_STAGES-1:0], txClk};
    end
  end

  assign rstLvl = rstChain[SYNC_STAGES-1];
  assign txEdge = txChain[SYNC_STAGES-1] & ~txChain[SYNC_STAGES];
  assign sysDone = (sysCnt == SYS_LIM);
  assign txDone = (txCnt == TX_LIM);

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      sysCnt <= '0;
      txCnt <= '0;
      coreReset <= 1'b0;
    end else if (!rstLvl) begin
      sysCnt <= '0;
      txCnt <= '0;
      coreReset <= 1'b0;
    end else begin
      if (!sysDone) sysCnt <= sysCnt + 1'b1;
      if (txEdge && !txDone) txCnt <= txCnt + 1'b1;
      coreReset <= coreReset | (sysDone & txDone);
    end
  end

  logic [3:0] hiRun;
  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) hiRun <= '0;
    else if (!rstChain[SYNC_STAGES-1]) hiRun <= '0;
    else if (hiRun != 4'hF) hiRun <= hiRun + 1'b1;
  end

  assert_reset_min_sys_R1: assert property (@(posedge clk) disable iff (!sysRstN)
    $rose(coreReset) |-> (hiRun >= 4'(SYS_MIN)));
  assert_reset_drops_R2: assert property (@(posedge clk) disable iff (!sysRstN)
    !rstLvl |=> !coreReset);
endmodule

// File: rtl/startCtrl.sv
module startCtrl
  import startSeqPkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic sysRstN,
  input  logic attnIn,
  input  logic coreReset,
  output logic initStart,
  output logic cmdStart,
  output seqStrobe_t strobes
);
  logic [SYNC_STAGES:0] attnChain;
  logic attnFall;
  logic firstPending;
  logic actNow;

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) attnChain <= '0;
    else attnChain <= {attnChain[SYNC_STAGES-1:0], attnIn};
  end

  assign attnFall = attnChain[SYNC_STAGES] & ~attnChain[SYNC_STAGES-1];
  assign actNow = attnFall & ~coreReset;

  always_comb begin
    strobes.clearAll = coreReset;
    strobes.latchInit = actNow & firstPending;
  end

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      firstPending <= 1'b1;
      initStart <= 1'b0;
      cmdStart <= 1'b0;
    end else if (coreReset) begin
      firstPending <= 1'b1;
      initStart <= 1'b0;
      cmdStart <= 1'b0;
    end else begin
      initStart <= actNow & firstPending;
      cmdStart <= actNow & ~firstPending;
      if (actNow) firstPending <= 1'b0;
    end
  end

  assert_pulse_exclusive_R7: assert property (@(posedge clk) disable iff (!sysRstN)
    !(initStart && cmdStart));
  assert_init_single_R7: assert property (@(posedge clk) disable iff (!sysRstN)
    initStart |=> !initStart);
  assert_cmd_single_R7: assert property (@(posedge clk) disable iff (!sysRstN)
    cmdStart |=> !cmdStart);
  assert_quiet_in_reset_R2: assert property (@(posedge clk) disable iff (!sysRstN)
    coreReset |=> !(initStart || cmdStart));
  assert_cmd_after_init_R4: assert property (@(posedge clk) disable iff (!sysRstN)
    cmdStart |-> !firstPending);
endmodule

// File: rtl/startData.sv
module startData
  import startSeqPkg::*;
(
  input  logic clk,
  input  logic sysRstN,
  input  seqStrobe_t strobes,
  input  logic portStrobe,
  input  logic [WORD_W-1:0] portData,
  output logic [WORD_W-1:0] initAddr
);
  logic [WORD_W-1:0] holdReg;
  logic holdValid;
  logic [WORD_W-1:0] addrReg;
  logic addrValid;
  logic commitSet;
  logic [WORD_W-1:0] newAddr;
  logic [WORD_W-1:0] effAddr;

  assign newAddr = {holdReg[WORD_W-1:TYPE_W], {TYPE_W{1'b0}}};
  assign commitSet = portStrobe & holdValid & ~strobes.clearAll &
                     (holdReg[TYPE_W-1:0] == PORT_SET_START);

  always_comb begin
    if (commitSet) effAddr = newAddr;
    else if (addrValid) effAddr = addrReg;
    else effAddr = DEFAULT_START;
  end

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      holdReg <= '0;
      holdValid <= 1'b0;
      addrReg <= '0;
      addrValid <= 1'b0;
    end else if (strobes.clearAll) begin
      holdValid <= 1'b0;
      addrValid <= 1'b0;
    end else if (portStrobe) begin
      if (!holdValid) begin
        holdReg <= portData;
        holdValid <= 1'b1;
      end else begin
        holdValid <= 1'b0;
        if (commitSet) begin
          addrReg <= newAddr;
          addrValid <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) initAddr <= '0;
    else if (strobes.latchInit) initAddr <= effAddr;
  end

  assert_reset_clears_R6: assert property (@(posedge clk) disable iff (!sysRstN)
    $past(strobes.clearAll) |-> (!addrValid && !holdValid));
  assert_commit_needs_pair_R5: assert property (@(posedge clk) disable iff (!sysRstN)
    $rose(addrValid) |-> $past(portStrobe && holdValid));
endmodule

// File: rtl/startSequencer.sv
module startSequencer
  import startSeqPkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SYS_MIN = 5,
  parameter int unsigned TX_MIN = 4
) (
  input  logic clk,
  input  logic sysRstN,
  input  logic txClk,
  input  logic resetIn,
  input  logic attnIn,
  input  logic portStrobe,
  input  logic [31:0] portData,
  output logic coreReset,
  output logic initStart,
  output logic [31:0] initAddr,
  output logic cmdStart
);
  seqStrobe_t strobes;

  startRstQual #(.SYNC_STAGES(SYNC_STAGES), .SYS_MIN(SYS_MIN), .TX_MIN(TX_MIN)) uQual (
    .clk(clk), .sysRstN(sysRstN), .txClk(txClk), .resetIn(resetIn), .coreReset(coreReset)
  );

  startCtrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .sysRstN(sysRstN), .attnIn(attnIn), .coreReset(coreReset),
    .initStart(initStart), .cmdStart(cmdStart), .strobes(strobes)
  );

  startData uData (
    .clk(clk), .sysRstN(sysRstN), .strobes(strobes), .portStrobe(portStrobe),
    .portData(portData), .initAddr(initAddr)
  );
endmodule

// File: tb/tb_startSequencer.sv
module tb_startSequencer;
  logic clk = 1'b0;
  logic sysRstN = 1'b0;
  logic txClk = 1'b0;
  logic txRun = 1'b1;
  logic resetIn = 1'b0;
  logic attnIn = 1'b0;
  logic portStrobe = 1'b0;
  logic [31:0] portData = '0;
  logic coreReset, initStart, cmdStart;
  logic [31:0] initAddr;

  int tests = 0;
  int fails = 0;
  int initCnt = 0;
  int cmdCnt = 0;
  int bothCnt = 0;
  logic [31:0] lastAddr = '0;
  logic sawCore = 1'b0;

  localparam logic [31:0] DEF = 32'h00FFFFF6;

  startSequencer dut (
    .clk(clk), .sysRstN(sysRstN), .txClk(txClk), .resetIn(resetIn), .attnIn(attnIn),
    .portStrobe(portStrobe), .portData(portData), .coreReset(coreReset),
    .initStart(initStart), .initAddr(initAddr), .cmdStart(cmdStart)
  );

  always #4 clk = ~clk;
  always #20 txClk = txRun ? ~txClk : 1'b0;

  always @(negedge clk) begin
    if (initStart) begin initCnt++; lastAddr = initAddr; end
    if (cmdStart) cmdCnt++;
    if (initStart && cmdStart) bothCnt++;
    if (coreReset) sawCore = 1'b1;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic portWrite(input logic [31:0] w);
    portData = w; portStrobe = 1'b1; tick(1);
    portStrobe = 1'b0; portData = '0; tick(1);
  endtask

  task automatic fullReset();
    resetIn = 1'b1; tick(40);
    check(coreReset == 1'b1, "R1 coreReset after long request", 32'(coreReset), 32'd1);
    resetIn = 1'b0; tick(6);
    check(coreReset == 1'b0, "R2 coreReset released", 32'(coreReset), 32'd0);
  endtask

  task automatic attention(output int di, output int dc);
    int i0, c0;
    i0 = initCnt; c0 = cmdCnt;
    attnIn = 1'b1; tick(3);
    attnIn = 1'b0; tick(8);
    di = initCnt - i0; dc = cmdCnt - c0;
  endtask

  // {doReset, doPort, word, expInit, expAddr}
  localparam int NV = 7;
  localparam logic [66:0] VEC [NV] = '{
    {1'b0, 1'b0, 32'h0, 1'b1, DEF},
    {1'b0, 1'b0, 32'h0, 1'b0, 32'h0},
    {1'b0, 1'b1, 32'h12345672, 1'b0, 32'h0},
    {1'b1, 1'b1, 32'hABCDE012, 1'b1, 32'hABCDE010},
    {1'b0, 1'b0, 32'h0, 1'b0, 32'h0},
    {1'b1, 1'b0, 32'h0, 1'b1, DEF},
    {1'b1, 1'b1, 32'h55555553, 1'b1, DEF}
  };

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int di, dc;
    tick(3);
    sysRstN = 1'b1;
    tick(2);
    check(!coreReset && !initStart && !cmdStart, "R3 reset state outputs idle",
          {29'd0, coreReset, initStart, cmdStart}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      logic [66:0] e;
      e = VEC[v];
      if (e[66]) fullReset();
      if (e[65]) begin portWrite(e[64:33]); portWrite(32'h0); end
      attention(di, dc);
      if (e[32]) begin
        check(di == 1 && dc == 0, "R3 first attention gives one init", 32'(di), 32'd1);
        check(lastAddr == e[31:0], "R5 init address", lastAddr, e[31:0]);
      end else begin
        check(dc == 1 && di == 0, "R4 later attention gives one cmd", 32'(dc), 32'd1);
      end
    end

    // R1: short request ignored
    sawCore = 1'b0;
    resetIn = 1'b1; tick(3); resetIn = 1'b0; tick(6);
    check(sawCore == 1'b0, "R1 short request ignored", 32'(sawCore), 32'd0);
    attention(di, dc);
    check(dc == 1 && di == 0, "R1 state kept after short request", 32'(dc), 32'd1);

    // R1: transmit clock stopped blocks reset
    txRun = 1'b0; sawCore = 1'b0;
    resetIn = 1'b1; tick(30);
    check(sawCore == 1'b0, "R1 no reset without txClk", 32'(sawCore), 32'd0);
    txRun = 1'b1; tick(30);
    check(coreReset == 1'b1, "R1 reset once txClk runs", 32'(coreReset), 32'd1);

    // R2: attention and port ignored while in reset
    portWrite(32'h11111112); portWrite(32'h0);
    attention(di, dc);
    check(di == 0 && dc == 0, "R2 attention ignored in reset", 32'(di + dc), 32'd0);
    resetIn = 1'b0; tick(6);
    attention(di, dc);
    check(di == 1 && lastAddr == DEF, "R2 port ignored in reset", lastAddr, DEF);

    // R6: half-finished access discarded by reset
    portWrite(32'h22222222);
    fullReset();
    portWrite(32'h33333332);
    attention(di, dc);
    check(di == 1 && lastAddr == DEF, "R6 pending hold discarded", lastAddr, DEF);

    // R9: held high gives nothing until it falls
    begin
      int i0, c0;
      i0 = initCnt; c0 = cmdCnt;
      attnIn = 1'b1; tick(12);
      check(initCnt == i0 && cmdCnt == c0, "R9 no pulse while high", 32'(cmdCnt - c0), 32'd0);
      attnIn = 1'b0; tick(8);
      check(cmdCnt == c0 + 1, "R9 pulse on fall", 32'(cmdCnt - c0), 32'd1);
    end

    // R8: commit in the same cycle as the recognized fall
    fullReset();
    portWrite(32'hCAFE0012);
    begin
      int i0;
      i0 = initCnt;
      attnIn = 1'b1; tick(3);
      attnIn = 1'b0; tick(2);
      portStrobe = 1'b1; portData = 32'h0; tick(1);
      portStrobe = 1'b0; tick(6);
      check(initCnt == i0 + 1, "R8 one init", 32'(initCnt - i0), 32'd1);
      check(lastAddr == 32'hCAFE0010, "R8 same-cycle commit used", lastAddr, 32'hCAFE0010);
    end

    check(bothCnt == 0, "R7 pulses never together", 32'(bothCnt), 32'd0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule